// File: doc/BRIEF.md
# Handshaked Control-Register Target

This block is the responding end of a narrow control-register bus on which a master moves both addresses and data over one shared 16-bit input. Four strobe lines select what the input word means. One strobe captures the word as the current address. Another captures it into a holding register. A third commits the holding register to the addressed location. The fourth returns the addressed location on the output bus.

Every accepted strobe is answered with an acknowledge level. The master must see that level rise, drop its strobe, and then see the level return low before it starts the next step. The block is used as the storage model behind a master that drives this protocol. A delay parameter stretches both acknowledge edges, so that the master's polling and timeout logic can be exercised.

Only a window of addresses, starting at a base and of parameterised size, is backed by storage. An event is accepted only when exactly one strobe has risen while the target is idle. Anything else is dropped and no acknowledge follows, so a faulty master times out.

Top module: `ctlreg_target`

## Requirements
- R1: After a synchronous reset, ack_o and bus_dout are 0, and every backed register, the latched address and the holding register read as zero.
- R2: An accepted capture-address event (cap_addr_i rising alone) latches bus_din as the address used by later write-commit and read events.
- R3: An accepted capture-data event (cap_data_i rising alone) latches bus_din into the holding register and leaves every stored register unchanged.
- R4: An accepted write-commit event (wr_i rising alone) copies the holding register into the register at the latched address. The holding register keeps its value, so it can be committed again.
- R5: During the acknowledge of a read event (rd_i rising alone), bus_dout shows the value the addressed register held when the strobe was sampled. Whenever ack_o is low, and during other events' acknowledges, bus_dout is zero.
- R6: ack_o rises exactly ACK_DELAY+1 clock edges after the edge that samples the accepted strobe's rise.
- R7: ack_o stays high while any strobe is high. Once all strobes are sampled low, it falls exactly ACK_DELAY+1 edges later.
- R8: Only addresses BASE_ADDR through BASE_ADDR+NUM_REGS-1 are backed. Other addresses read as zero, and write-commits to them change no register. The first and last backed addresses are distinct registers.
- R9: If more than one strobe is high when a rise is sampled in idle, nothing happens. ack_o stays low, and the address, holding and stored registers keep their values.
- R10: Strobe rises sampled while a handshake is in progress (ack pending, high or falling) are ignored. A strobe still high when the target returns to idle does not start a new event until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_addr_i | input | 1 | Capture-address strobe |
| cap_data_i | input | 1 | Capture-data strobe |
| wr_i | input | 1 | Write-commit strobe |
| rd_i | input | 1 | Read strobe |
| bus_din | input | DATA_W | Shared address/data input word |
| bus_dout | output | DATA_W | Read data, valid while a read is acknowledged |
| ack_o | output | 1 | Acknowledge level |

## Verification
A corrupted latched address or holding register stays invisible until a later write-commit lands. It shows only when that location is read back, several handshakes after the fault, so the bench always writes and then reads back through different address and data sequences. A handshake controller stuck in the wrong phase shows within ACK_DELAY+2 cycles as an acknowledge edge that comes early, comes late or never comes. The bench models the expected acknowledge level and read word on every cycle and compares them, which catches such faults at the first wrong cycle and not only at the end of a transfer.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_RISE = 2'd1,
        HS_HELD = 2'd2,
        HS_FALL = 2'd3
    } hs_state_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_ADDR  = 3'd1,
        EV_DATA  = 3'd2,
        EV_WRITE = 3'd3,
        EV_READ  = 3'd4
    } ev_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic cap_data;
        logic cap_addr;
    } strobe_t;

    function automatic logic single_hot(input strobe_t s);
        logic [3:0] v;
        v = s;
        return (v != 4'd0) && ((v & (v - 4'd1)) == 4'd0);
    endfunction

    function automatic ev_kind_e strobe_kind(input strobe_t s);
        if (s.cap_addr) return EV_ADDR;
        if (s.cap_data) return EV_DATA;
        if (s.wr)       return EV_WRITE;
        if (s.rd)       return EV_READ;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/ctlreg_strobe_decode.sv
module ctlreg_strobe_decode
    import ctlreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  strobe_t  stb,
    input  logic     idle,
    output ev_kind_e ev
);
    strobe_t prev_q;
    strobe_t rise;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stb;
    end

    always_comb begin
        rise = stb & ~prev_q;
        ev   = EV_NONE;
        if (idle && (rise != '0) && single_hot(stb))
            ev = strobe_kind(stb);
    end
endmodule

// File: rtl/ctlreg_ack_timer.sv
module ctlreg_ack_timer
    import ctlreg_pkg::*;
#(
    parameter int unsigned ACK_DELAY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      strobes_low,
    output logic      ack,
    output hs_state_e state
);
    localparam int unsigned CNT_W = (ACK_DELAY > 0) ? $clog2(ACK_DELAY + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            cnt_q <= '0;
            ack   <= 1'b0;
        end else begin
            unique case (state)
                HS_IDLE: if (start) begin
                    state <= HS_RISE;
                    cnt_q <= CNT_LOAD;
                end
                HS_RISE: if (cnt_q == '0) begin
                    ack   <= 1'b1;
                    state <= HS_HELD;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                HS_HELD: if (strobes_low) begin
                    state <= HS_FALL;
                    cnt_q <= CNT_LOAD;
                end
                HS_FALL: if (cnt_q == '0) begin
                    ack   <= 1'b0;
                    state <= HS_IDLE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctlreg_regfile.sv
module ctlreg_regfile
    import ctlreg_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [DATA_W-1:0] BASE_ADDR = 16'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_kind_e          ev,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int unsigned OFF_W = DATA_W + 1;

    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] mem_q [NUM_REGS];
    logic [OFF_W-1:0]  offset;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign offset = {1'b0, addr_q} - {1'b0, BASE_ADDR};
    assign hit    = offset < OFF_W'(NUM_REGS);
    assign idx    = offset[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            hold_q <= '0;
            rdata  <= '0;
        end else begin
            if (ev == EV_ADDR) addr_q <= din;
            if (ev == EV_DATA) hold_q <= din;
            if (ev != EV_NONE)
                rdata <= (ev == EV_READ && hit) ? mem_q[idx] : '0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (rst)
                mem_q[i] <= '0;
            else if (ev == EV_WRITE && hit && idx == IDX_W'(i))
                mem_q[i] <= hold_q;
        end
    end
endmodule

// File: rtl/ctlreg_target.sv
module ctlreg_target
    import ctlreg_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_REGS  = 8,
    parameter logic [DATA_W-1:0] BASE_ADDR = 16'h1000,
    parameter int unsigned ACK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_addr_i,
    input  logic              cap_data_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              ack_o
);
    strobe_t           stb;
    ev_kind_e          ev;
    hs_state_e         hs_state;
    logic [DATA_W-1:0] rdata;

    assign stb = '{rd: rd_i, wr: wr_i, cap_data: cap_data_i, cap_addr: cap_addr_i};

    ctlreg_strobe_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .idle (hs_state == HS_IDLE),
        .ev   (ev)
    );

    ctlreg_ack_timer #(.ACK_DELAY(ACK_DELAY)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (ev != EV_NONE),
        .strobes_low (stb == '0),
        .ack         (ack_o),
        .state       (hs_state)
    );

    ctlreg_regfile #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .din   (bus_din),
        .rdata (rdata)
    );

    assign bus_dout = ack_o ? rdata : '0;
endmodule

// File: rtl/ctlreg_target_chk.sv
module ctlreg_target_chk
    import ctlreg_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ACK_DELAY = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        stb,
    input hs_state_e         state,
    input logic              ack,
    input logic [DATA_W-1:0] dout
);
    int rise_cnt;
    int fall_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= 0;
            fall_cnt <= 0;
        end else begin
            rise_cnt <= (state == HS_RISE) ? rise_cnt + 1 : 0;
            fall_cnt <= (state == HS_FALL) ? fall_cnt + 1 : 0;
        end
    end

    // R5: the output word is zero whenever ack is low
    assert_dout_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !ack |-> dout == '0);

    // R6: acknowledge rises after the configured wait
    assert_rise_wait_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack) && !$past(rst)) |-> rise_cnt == int'(ACK_DELAY) + 1);

    // R7: acknowledge held while a strobe is up, then falls after the wait
    assert_ack_held_R7: assert property (@(posedge clk) disable iff (rst)
        (state == HS_HELD && stb != 4'd0) |=> ack);

    assert_fall_wait_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack) && !$past(rst)) |-> fall_cnt == int'(ACK_DELAY) + 1);

    // R9: colliding strobes never start a handshake
    assert_collision_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state == HS_IDLE && $countones(stb) > 1) |=> state == HS_IDLE);
endmodule

bind ctlreg_target ctlreg_target_chk #(
    .DATA_W    (DATA_W),
    .ACK_DELAY (ACK_DELAY)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .stb   ({rd_i, wr_i, cap_data_i, cap_addr_i}),
    .state (hs_state),
    .ack   (ack_o),
    .dout  (bus_dout)
);

// File: tb/ctlreg_target_test.sv
`timescale 1ns/1ps
module ctlreg_target_test;
    localparam int DW    = 16;
    localparam int NREGS = 8;
    localparam int BASE  = 16'h1000;
    localparam int DLY   = 2;
    localparam logic [3:0] M_CA = 4'b0001, M_CD = 4'b0010, M_WR = 4'b0100, M_RD = 4'b1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ca = 0, cd = 0, wr = 0, rd = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic ack;

    int vectors = 0;
    int fails = 0;
    bit compare_on = 0;
    string phase_req = "R1";

    always #2.5 clk = ~clk;

    ctlreg_target #(.DATA_W(DW), .NUM_REGS(NREGS), .BASE_ADDR(16'(BASE)), .ACK_DELAY(DLY)) uut (
        .clk(clk), .rst(rst), .cap_addr_i(ca), .cap_data_i(cd), .wr_i(wr), .rd_i(rd),
        .bus_din(din), .bus_dout(dout), .ack_o(ack));

    // behavioural reference
    int phase_m, wait_m;
    logic [3:0] prev_m;
    int addr_m, hold_m, dout_m;
    bit ack_m;
    int mem_m [int];

    function automatic bit backed(int a);
        return a >= BASE && a < BASE + NREGS;
    endfunction

    always @(posedge clk) begin
        logic [3:0] cur;
        cur = {rd, wr, cd, ca};
        if (rst) begin
            phase_m = 0; wait_m = 0; prev_m = 0; addr_m = 0; hold_m = 0;
            dout_m = 0; ack_m = 0; mem_m.delete();
        end else begin
            if (phase_m == 0) begin
                if ((cur & ~prev_m) != 0 && $countones(cur) == 1) begin
                    dout_m = 0;
                    if (cur == M_CA) addr_m = int'(din);
                    else if (cur == M_CD) hold_m = int'(din);
                    else if (cur == M_WR) begin
                        if (backed(addr_m)) mem_m[addr_m] = hold_m;
                    end else if (backed(addr_m) && mem_m.exists(addr_m)) dout_m = mem_m[addr_m];
                    phase_m = 1; wait_m = DLY;
                end
            end else if (phase_m == 1) begin
                if (wait_m == 0) begin ack_m = 1; phase_m = 2; end else wait_m--;
            end else if (phase_m == 2) begin
                if (cur == 0) begin phase_m = 3; wait_m = DLY; end
            end else begin
                if (wait_m == 0) begin ack_m = 0; phase_m = 0; end else wait_m--;
            end
            prev_m = cur;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, R6/R7 for ack and R5 for the word
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            check({phase_req, " ack R6 R7"}, int'(ack), int'(ack_m));
            check({phase_req, " dout R5"}, int'(dout), ack_m ? dout_m : 0);
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic hs(input logic [3:0] m, input int d, output int rv, output int rc, output int fc);
        @(negedge clk);
        {rd, wr, cd, ca} = m; din = 16'(d); rc = 0;
        do begin @(negedge clk); rc++; end while (!ack && rc < 40);
        rv = int'(dout);
        {rd, wr, cd, ca} = 4'b0; fc = 0;
        do begin @(negedge clk); fc++; end while (ack && fc < 40);
    endtask

    task automatic wr_reg(input int a, input int d);
        int rv, rc, fc;
        hs(M_CA, a, rv, rc, fc);
        hs(M_CD, d, rv, rc, fc);
        hs(M_WR, 0, rv, rc, fc);
    endtask

    task automatic rd_reg(input int a, output int v);
        int rc, fc;
        hs(M_CA, a, v, rc, fc);
        hs(M_RD, 0, v, rc, fc);
    endtask

    initial begin
        int v, rc, fc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_on = 1;
        @(negedge clk);
        check("R1 ack after reset", int'(ack), 0);
        check("R1 dout after reset", int'(dout), 0);
        rd_reg(BASE + 4, v);
        check("R1 register cleared", v, 0);

        phase_req = "R2";
        wr_reg(BASE + 3, 16'hA5A5);
        rd_reg(BASE + 3, v);
        check("R2 R4 write then read", v, 16'hA5A5);

        phase_req = "R3";
        hs(M_CD, 16'h1234, v, rc, fc);
        rd_reg(BASE + 3, v);
        check("R3 capture-data leaves storage", v, 16'hA5A5);
        hs(M_WR, 0, v, rc, fc);
        hs(M_RD, 0, v, rc, fc);
        check("R4 hold committed", v, 16'h1234);
        hs(M_CA, BASE + 6, v, rc, fc);
        hs(M_WR, 0, v, rc, fc);
        rd_reg(BASE + 6, v);
        check("R4 hold reused", v, 16'h1234);

        phase_req = "R5";
        hs(M_CA, BASE + 3, v, rc, fc);
        check("R5 dout zero on address ack", v, 0);
        @(negedge clk);
        check("R5 dout zero when idle", int'(dout), 0);

        phase_req = "R6";
        hs(M_RD, 0, v, rc, fc);
        check("R6 ack rise cycles", rc, DLY + 2);
        check("R7 ack fall cycles", fc, DLY + 2);

        phase_req = "R7";
        @(negedge clk); rd = 1;
        while (!ack) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R7 ack held with strobe", int'(ack), 1);
        end
        rd = 0;
        while (ack) @(negedge clk);

        phase_req = "R8";
        wr_reg(BASE, 16'h0101);
        wr_reg(BASE + NREGS - 1, 16'h7E7E);
        rd_reg(BASE, v);
        check("R8 first backed", v, 16'h0101);
        rd_reg(BASE + NREGS - 1, v);
        check("R8 last backed", v, 16'h7E7E);
        wr_reg(BASE + NREGS, 16'hBEEF);
        rd_reg(BASE + NREGS, v);
        check("R8 unbacked reads zero", v, 0);
        wr_reg(BASE - 1, 16'hCAFE);
        rd_reg(BASE - 1, v);
        check("R8 below window reads zero", v, 0);
        rd_reg(BASE, v);
        check("R8 neighbour untouched", v, 16'h0101);
        wr_reg(16'h0005, 16'h5555);
        rd_reg(BASE + 5, v);
        check("R8 no alias", v, 0);

        phase_req = "R9";
        wr_reg(BASE + 2, 16'h2222);
        @(negedge clk); {rd, wr, cd, ca} = M_CA | M_WR; din = 16'(BASE + 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R9 no ack on collision", int'(ack), 0);
        end
        {rd, wr, cd, ca} = 4'b0;
        @(negedge clk);
        hs(M_RD, 0, v, rc, fc);
        check("R9 address kept", v, 16'h2222);
        hs(M_CA, BASE + 1, v, rc, fc);
        hs(M_WR, 0, v, rc, fc);
        hs(M_RD, 0, v, rc, fc);
        check("R9 hold kept", v, 16'h2222);

        phase_req = "R10";
        @(negedge clk); rd = 1;
        while (!ack) @(negedge clk);
        rd = 0;
        @(negedge clk); cd = 1; din = 16'hDEAD;
        while (ack) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10 no restart from held strobe", int'(ack), 0);
        cd = 0;
        hs(M_WR, 0, v, rc, fc);
        hs(M_RD, 0, v, rc, fc);
        check("R10 busy capture ignored", v, 16'h2222);

        repeat (3) @(negedge clk);
        compare_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule